// File: doc/BRIEF.md
# Timer Capture and Compare Unit

This block sits beside a free-running 16-bit timer that lives elsewhere in the chip. It owns one 16-bit capture/compare register, one input pin, one output pin and one interrupt flag. A single 4-bit mode field decides what the unit does with them. In the capture modes the unit watches the input pin and, on the selected edge event, stores the timer value it sees into the register. The timer keeps running. Selectable events are a falling edge, a rising edge, every 4th rising edge or every 16th rising edge.

In the compare modes the unit compares the register against the timer on every clock. On the first clock of equality it drives the output pin high or low, toggles it, or only raises the interrupt. Software loads the register one byte at a time and clears the interrupt flag with a pulse. The input pin passes through a two-flop synchronizer before edge detection.

Top module: `capcmp_unit`

## Requirements
- R1: After reset, ccr_o is 0, pin_o is 0 and irq_o is 0.
- R2: wr_en_i bit 0 loads wdata_i into ccr_o[7:0] and bit 1 loads it into ccr_o[15:8]. Both bits may be set in the same cycle. The new value shows after the clock edge. A capture event in the same cycle takes precedence over the write.
- R3: Mode 0000, and every code not listed in R4, R5, R7 and R9 (0001, 0011, 1011 to 1111), disables the unit. It makes no capture and no compare action, so ccr_o, pin_o and irq_o change only through writes and irq_clr_i.
- R4: Mode 0100 captures on a falling edge of pin_i and mode 0101 captures on a rising edge. A pin_i transition sampled at clock edge n is acted on at edge n+2. After that edge, ccr_o holds timer_i as sampled at edge n+2.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 captures on every 16th rising edge. Edges are counted from the last change of mode_i. The clock in which mode_i changes clears the count, and a rising edge in that clock is not counted.
- R6: Each capture overwrites the earlier captured value, even if irq_o is still set and nothing has read it.
- R7: Mode 1000 forces pin_o to 1, mode 1001 forces it to 0 and mode 0010 toggles it. The action happens at the first clock edge where timer_i equals ccr_o, and pin_o shows it after that edge. In the other modes pin_o holds its value.
- R8: A compare action fires once per match. While timer_i stays equal to ccr_o on consecutive edges, no further action and no further interrupt happens.
- R9: Mode 1010 sets irq_o on a match and leaves pin_o unchanged.
- R10: Every capture event, and every first-match edge in modes 0010, 1000, 1001 and 1010, sets irq_o. A pulse on irq_clr_i clears irq_o. If an event and a clear fall in the same cycle, irq_o ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Mode field (encodings in R3, R4, R5, R7, R9) |
| timer_i | input | 16 | Free-running timer value |
| pin_i | input | 1 | Asynchronous capture input pin |
| wr_en_i | input | 2 | Byte write enables: bit 0 low byte, bit 1 high byte |
| wdata_i | input | 8 | Byte write data |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ccr_o | output | 16 | Capture/compare register |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions check these properties on every cycle:
- a capture loads the timer value from the event clock;
- any event raises the flag;
- force modes drive the pin to the set level, and the interrupt-only mode leaves it alone;
- a compare fires once per match;
- rising-edge events never come back to back;
- the prescale count stays within its range;
- the disabled mode produces no event at all.

Only the bench scenarios can show the end-to-end quantities: the two-clock synchronizer latency, the exact 4th and 16th edge counted from a mode change, toggle sequences across several matches, and clear and event landing in the same cycle. These are checked against a cycle model computed in the bench from the requirements, under random pin activity and random mode changes.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    typedef enum logic [3:0] {
        M_OFF    = 4'b0000,
        M_TOGGLE = 4'b0010,
        M_FALL   = 4'b0100,
        M_RISE   = 4'b0101,
        M_RISE_A = 4'b0110,
        M_RISE_B = 4'b0111,
        M_SET    = 4'b1000,
        M_CLR    = 4'b1001,
        M_IRQ    = 4'b1010
    } mode_e;

    typedef enum logic [2:0] {
        CAP_NONE, CAP_FALL, CAP_RISE, CAP_RISE_A, CAP_RISE_B
    } cap_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_SET, ACT_CLR, ACT_TOG, ACT_IRQ
    } act_e;

    typedef struct packed {
        cap_e cap;
        act_e act;
        logic cmp;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [3:0] m);
        mode_dec_t r;
        r = '{cap: CAP_NONE, act: ACT_NONE, cmp: 1'b0};
        case (m)
            M_FALL:   r.cap = CAP_FALL;
            M_RISE:   r.cap = CAP_RISE;
            M_RISE_A: r.cap = CAP_RISE_A;
            M_RISE_B: r.cap = CAP_RISE_B;
            M_TOGGLE: begin r.act = ACT_TOG; r.cmp = 1'b1; end
            M_SET:    begin r.act = ACT_SET; r.cmp = 1'b1; end
            M_CLR:    begin r.act = ACT_CLR; r.cmp = 1'b1; end
            M_IRQ:    begin r.act = ACT_IRQ; r.cmp = 1'b1; end
            default:  ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge
    import capcmp_pkg::*;
#(
    parameter int SYNC  = 2,
    parameter int PRE_A = 4,
    parameter int PRE_B = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  cap_e kind_i,
    input  logic mode_chg_i,
    output logic ev_o
);
    localparam int CW = (PRE_B > 1) ? $clog2(PRE_B) : 1;
    localparam logic [CW-1:0] LIM_A = CW'(PRE_A - 1);
    localparam logic [CW-1:0] LIM_B = CW'(PRE_B - 1);

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            last;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t q, d;
    logic rise, fall, presc;
    logic [CW-1:0] lim;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC-2:0], pin_i};
        d.last = q.sync[SYNC-1];
        rise   = q.sync[SYNC-1] & ~q.last;
        fall   = ~q.sync[SYNC-1] & q.last;
        presc  = (kind_i == CAP_RISE_A) || (kind_i == CAP_RISE_B);
        lim    = (kind_i == CAP_RISE_A) ? LIM_A : LIM_B;

        if (mode_chg_i)
            d.cnt = '0;
        else if (presc && rise)
            d.cnt = (q.cnt == lim) ? '0 : q.cnt + 1'b1;

        case (kind_i)
            CAP_FALL:   ev_o = fall;
            CAP_RISE:   ev_o = rise;
            CAP_RISE_A,
            CAP_RISE_B: ev_o = rise && !mode_chg_i && (q.cnt == lim);
            default:    ev_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == CAP_RISE && ev_o) |=> !ev_o); // R4
    AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == CAP_RISE_A && $past(kind_i) == CAP_RISE_A) |-> (q.cnt < CW'(PRE_A))); // R5

endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] timer_i,
    input  logic [W-1:0] ref_i,
    output logic         fire_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t q, d;
    logic eq;

    always_comb begin
        eq     = en_i && (timer_i == ref_i);
        d.prev = eq;
        fire_o = eq && !q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o); // R8

endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
    import capcmp_pkg::*;
#(
    parameter int TW    = 16,
    parameter int BW    = 8,
    parameter int SYNC  = 2,
    parameter int PRE_A = 4,
    parameter int PRE_B = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode_i,
    input  logic [TW-1:0] timer_i,
    input  logic          pin_i,
    input  logic [TW/BW-1:0] wr_en_i,
    input  logic [BW-1:0] wdata_i,
    input  logic          irq_clr_i,
    output logic [TW-1:0] ccr_o,
    output logic          pin_o,
    output logic          irq_o
);
    localparam int NB = TW / BW;

    typedef struct packed {
        logic [TW-1:0] ccr;
        logic          pin;
        logic          irq;
        logic [3:0]    mode_prev;
    } st_t;

    st_t q, d;
    mode_dec_t dec;
    logic mode_chg, cap_ev, cmp_fire;
    logic [TW-1:0] wr_word;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign wr_word[b*BW +: BW] = wr_en_i[b] ? wdata_i : q.ccr[b*BW +: BW];
    end

    assign dec      = decode_mode(mode_i);
    assign mode_chg = (mode_i != q.mode_prev);

    capcmp_edge #(.SYNC(SYNC), .PRE_A(PRE_A), .PRE_B(PRE_B)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .kind_i     (dec.cap),
        .mode_chg_i (mode_chg),
        .ev_o       (cap_ev)
    );

    capcmp_match #(.W(TW)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (dec.cmp),
        .timer_i (timer_i),
        .ref_i   (q.ccr),
        .fire_o  (cmp_fire)
    );

    always_comb begin
        d           = q;
        d.mode_prev = mode_i;
        d.ccr       = cap_ev ? timer_i : wr_word;
        if (cmp_fire) begin
            case (dec.act)
                ACT_SET: d.pin = 1'b1;
                ACT_CLR: d.pin = 1'b0;
                ACT_TOG: d.pin = ~q.pin;
                default: d.pin = q.pin;
            endcase
        end
        if (cap_ev || cmp_fire) d.irq = 1'b1;
        else if (irq_clr_i)     d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ccr_o = q.ccr;
    assign pin_o = q.pin;
    assign irq_o = q.irq;

    AST_CAPTURE_TAKES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (ccr_o == $past(timer_i))); // R4
    AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev || cmp_fire) |=> irq_o); // R10
    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_fire && mode_i == M_SET) |=> pin_o); // R7
    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_fire && mode_i == M_CLR) |=> !pin_o); // R7
    AST_IRQ_ONLY_KEEPS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_fire && mode_i == M_IRQ) |=> $stable(pin_o)); // R9
    AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_OFF) |-> (!cap_ev && !cmp_fire)); // R3
    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_ev && wr_en_i[0]) |=> (ccr_o[BW-1:0] == $past(wdata_i))); // R2

endmodule

// File: tb/tb_capcmp_unit.sv
`timescale 1ns/1ps
module tb_capcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic [15:0] timer = 16'h0000;
    logic        pin = 1'b0;
    logic [1:0]  wr_en = 2'b00;
    logic [7:0]  wdata = 8'h00;
    logic        clr = 1'b0;
    logic [15:0] ccr_o;
    logic        pin_o, irq_o;

    int vectors = 0;
    int fails = 0;
    int tstep = 1;

    logic [15:0] m_ccr;
    logic        m_pin, m_irq, s0, s1, s2, m_peq;
    logic [3:0]  m_pm;
    int          m_cnt;

    always #2.5 clk = ~clk;

    capcmp_unit dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .timer_i(timer), .pin_i(pin),
        .wr_en_i(wr_en), .wdata_i(wdata), .irq_clr_i(clr),
        .ccr_o(ccr_o), .pin_o(pin_o), .irq_o(irq_o)
    );

    function automatic int kind_of(input logic [3:0] m);
        case (m)
            4'b0100: return 1;
            4'b0101: return 2;
            4'b0110: return 3;
            4'b0111: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int act_of(input logic [3:0] m);
        case (m)
            4'b1000: return 1;
            4'b1001: return 2;
            4'b0010: return 3;
            4'b1010: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_ccr = '0; m_pin = 0; m_irq = 0; s0 = 0; s1 = 0; s2 = 0;
        m_peq = 0; m_pm = 4'b0000; m_cnt = 0;
    endtask

    task automatic model_edge();
        int k, a, lim;
        logic chg, rise, fall, ev, eq, fire;
        logic [15:0] nccr;
        chg  = (mode != m_pm);
        rise = s1 && !s2;
        fall = !s1 && s2;
        k    = kind_of(mode);
        lim  = (k == 3) ? 3 : 15;
        ev   = 1'b0;
        case (k)
            1: ev = fall;
            2: ev = rise;
            3, 4: ev = rise && !chg && (m_cnt == lim);
            default: ev = 1'b0;
        endcase
        if (chg) m_cnt = 0;
        else if ((k == 3 || k == 4) && rise) m_cnt = (m_cnt == lim) ? 0 : m_cnt + 1;
        a    = act_of(mode);
        eq   = (a != 0) && (timer == m_ccr);
        fire = eq && !m_peq;
        m_peq = eq;
        nccr = m_ccr;
        if (wr_en[0]) nccr[7:0]  = wdata;
        if (wr_en[1]) nccr[15:8] = wdata;
        if (ev) nccr = timer;
        if (fire) begin
            if (a == 1) m_pin = 1'b1;
            else if (a == 2) m_pin = 1'b0;
            else if (a == 3) m_pin = ~m_pin;
        end
        if (ev || fire) m_irq = 1'b1;
        else if (clr)   m_irq = 1'b0;
        s2 = s1; s1 = s0; s0 = pin;
        m_pm = mode;
        m_ccr = nccr;
    endtask

    task automatic check(input string tag);
        vectors++;
        if (ccr_o !== m_ccr || pin_o !== m_pin || irq_o !== m_irq) begin
            fails++;
            $display("FAIL %s: ccr=%h pin=%b irq=%b expected ccr=%h pin=%b irq=%b",
                     tag, ccr_o, pin_o, irq_o, m_ccr, m_pin, m_irq);
        end
    endtask

    // one clock: model the coming edge, let it happen, compare, advance timer
    task automatic cyc(input string tag);
        model_edge();
        @(posedge clk);
        #1;
        check(tag);
        timer = timer + 16'(tstep);
        wr_en = 2'b00;
        clr = 1'b0;
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic write_ccr(input logic [15:0] v, input string tag);
        wr_en = 2'b01; wdata = v[7:0];  cyc(tag);
        wr_en = 2'b10; wdata = v[15:8]; cyc(tag);
    endtask

    task automatic square(input string tag, input int edges, input int half);
        for (int e = 0; e < edges; e++) begin
            pin = 1'b1; run(tag, half);
            pin = 1'b0; run(tag, half);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] tgt;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset");
        rst_n = 1'b1;
        run("R1 idle", 3);

        // R2: byte writes
        write_ccr(16'hA55A, "R2");
        wr_en = 2'b11; wdata = 8'h3C; cyc("R2 both bytes");
        clr = 1'b1; cyc("R2");

        // R3: off and unlisted codes ignore the pin and matches
        tstep = 1;
        for (int c = 0; c < 2; c++) begin
            mode = (c == 0) ? 4'b0000 : 4'b1100;
            timer = 16'h3C3A;
            for (int i = 0; i < 12; i++) begin pin = ~pin; cyc("R3"); end
        end
        pin = 1'b0; run("R3", 4);

        // R4: falling and rising capture with random timer steps
        mode = 4'b0100; run("R4", 4);
        for (int i = 0; i < 60; i++) begin
            tstep = $urandom_range(1, 5);
            pin = 1'($urandom_range(0, 1));
            cyc("R4 fall");
        end
        mode = 4'b0101; pin = 1'b0; run("R4", 4);
        for (int i = 0; i < 60; i++) begin
            tstep = $urandom_range(1, 5);
            pin = 1'($urandom_range(0, 1));
            cyc("R4 rise");
        end

        // R6: overwrite while irq still set (no clear)
        square("R6 overwrite", 5, 3);

        // R2 collision: capture wins over write in same cycle
        pin = 1'b1; cyc("R2"); pin = 1'b0; cyc("R2");
        wr_en = 2'b11; wdata = 8'hEE; cyc("R2 capture beats write");
        run("R2", 3);

        // R5: prescaled captures, mode changes restart the count
        mode = 4'b0110; square("R5 every 4th", 10, 2);
        mode = 4'b0111; square("R5 every 16th", 20, 2);
        mode = 4'b0110; square("R5 restart", 6, 3);
        mode = 4'b0111; square("R5 restart", 34, 2);

        // R7: force high, force low, toggle
        tstep = 1;
        mode = 4'b0000; clr = 1'b1; cyc("R7");
        tgt = 16'h1234; write_ccr(tgt, "R7");
        mode = 4'b1000; timer = tgt - 16'd4; run("R7 force high", 8);
        mode = 4'b1001; timer = tgt - 16'd4; run("R7 force low", 8);
        mode = 4'b0010;
        for (int i = 0; i < 3; i++) begin
            timer = tgt - 16'd3; run("R7 toggle", 6);
        end

        // R8: timer held at the match value
        tstep = 0; timer = tgt;
        mode = 4'b0010; run("R8 held match", 8);
        mode = 4'b1000; run("R8 held match", 4);
        mode = 4'b1001; run("R8 held match", 4);

        // R9: interrupt only
        tstep = 1; clr = 1'b1; mode = 4'b1010; cyc("R9");
        timer = tgt - 16'd2; run("R9 irq only", 6);

        // R10: clear and event in the same cycle, then plain clear
        mode = 4'b0101; pin = 1'b0; run("R10", 4);
        pin = 1'b1; cyc("R10"); cyc("R10");
        clr = 1'b1; cyc("R10 set beats clear");
        clr = 1'b1; cyc("R10 clear");
        pin = 1'b0; run("R10", 3);

        // random mix of every behaviour
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                case ($urandom_range(0, 9))
                    0: mode = 4'b0000; 1: mode = 4'b0010; 2: mode = 4'b0100;
                    3: mode = 4'b0101; 4: mode = 4'b0110; 5: mode = 4'b0111;
                    6: mode = 4'b1000; 7: mode = 4'b1001; 8: mode = 4'b1010;
                    default: mode = 4'b1111;
                endcase
            end
            if ($urandom_range(0, 3) == 0) pin = ~pin;
            if ($urandom_range(0, 15) == 0) begin
                wr_en = 2'($urandom_range(1, 3));
                wdata = 8'($urandom);
            end
            if ($urandom_range(0, 7) == 0) clr = 1'b1;
            tstep = $urandom_range(0, 2);
            if ($urandom_range(0, 31) == 0) timer = m_ccr - 16'd1;
            cyc("random mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule